// File: doc/BRIEF.md
# Command Slot Dispatcher for a Serial-ATA Host Port

This block owns the command-issue bit vector of one host port that has 32 command slots. Software marks slots as ready by writing ones into that vector and enables the port with a run bit. While the port runs, the dispatcher looks for ready slots from the lowest index upward. It hands one command at a time to a device engine, together with the slot number, the opcode and a flag that says whether the command is queued.

A slot's issue bit is not cleared at the moment it is dispatched. A queued command gives up its bit one cycle after dispatch, at queue acceptance. A non-queued command keeps its bit until the engine signals completion. In both cases the bit is cleared only if the engine is then neither busy nor requesting data. If the gate blocks a clear, the bit stays set and the slot is offered again on a later scan.

Before a command goes out, the dispatcher reads that slot's command-frame length and opcode through a small header lookup port. A frame whose length is not 128 bytes is never dispatched. It raises a host-bus fatal pulse and stops the port.

Top module: `cmd_slot_dispatcher`

## Requirements
- R1: A synchronous reset clears the issue vector and the run bit and sets the active-slot register to 6'h3F, which means "no slot". No dispatch follows reset until software writes.
- R2: Slots are dispatched only while the run bit is set and at least one issue bit is set. Among the set bits, the lowest index goes first.
- R3: While `eng_busy` or `eng_drq` is high, nothing is dispatched and the issue bits stay set. Dispatch resumes once both inputs are low.
- R4: If the header length is not 128, the block raises a one-cycle `irq_hbf` pulse. It does not dispatch the slot, it leaves the slot's issue bit set and it clears the run bit.
- R5: A dispatch is a one-cycle `disp_valid` pulse. It carries the slot number, the opcode taken from the command frame's byte at offset 2 (`hdr_cmd_byte`) and the queued flag. It appears at the second clock edge after the edge that stores the enabling write.
- R6: For a queued command, the issue bit is cleared at the edge one cycle after dispatch, but only if `eng_busy` and `eng_drq` are both low. If the bit is not cleared, the slot is dispatched again later. If `eng_err` is high in that cycle, `irq_tfe` pulses. No `irq_d2h` is raised.
- R7: For a non-queued command, the slot number is recorded in the active-slot register at dispatch and its issue bit is left set. No further slot is dispatched until completion.
- R8: When `eng_done` arrives while a slot is active, the block pulses `irq_d2h` and returns the active-slot register to 6'h3F. It pulses `irq_tfe` if `eng_err` is high. It clears the slot's issue bit only if `eng_busy` and `eng_drq` are both low.
- R9: After a non-queued completion, any remaining issue bits are scanned again, and the next slot is dispatched two edges after the completion edge.
- R10: Issue bits are only set by software (write-1-to-set) and only cleared by the dispatcher. If a set and a clear hit the same bit in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_wr | input | 1 | Strobe for the issue-set write |
| issue_set | input | 32 | Bits to set in the issue vector |
| start_wr | input | 1 | Strobe for the run-bit write |
| start_val | input | 1 | New run-bit value |
| eng_busy | input | 1 | Engine busy |
| eng_drq | input | 1 | Engine data request |
| eng_err | input | 1 | Engine error status |
| eng_done | input | 1 | Non-queued command completion pulse |
| hdr_slot | output | 5 | Slot whose header is being looked up |
| hdr_fis_len | input | 8 | Command-frame length in bytes for `hdr_slot` |
| hdr_cmd_byte | input | 8 | Command-frame byte 2 (the opcode) for `hdr_slot` |
| hdr_ncq | input | 1 | The command in `hdr_slot` is queued |
| disp_valid | output | 1 | Dispatch pulse |
| disp_slot | output | 5 | Dispatched slot |
| disp_opcode | output | 8 | Dispatched opcode |
| disp_ncq | output | 1 | Dispatched command is queued |
| irq_hbf | output | 1 | Host-bus fatal pulse (bad frame length) |
| irq_tfe | output | 1 | Task-file error pulse |
| irq_d2h | output | 1 | Device-to-host register pulse |
| ci_bits | output | 32 | Current issue vector |
| port_run | output | 1 | Current run bit |
| active_slot | output | 6 | Non-queued slot in flight, or 6'h3F |

## Verification
A write is stored at edge E1. The slot is picked at E2, and the dispatch pulse and the fatal-length pulse are visible after E3. A queued clear, and the error pulse that goes with it, is visible after E4. A completion acts at its own edge, and the next dispatch is visible two edges later. Each task drives its inputs one time unit after an edge and checks at these exact edges. Where a slot must wait, the task checks at every cycle that no dispatch pulse appears.

// File: rtl/cslot_pkg.sv
package cslot_pkg;
  typedef enum logic [1:0] {PH_SCAN, PH_LOOK, PH_ACCEPT} phase_e;
  localparam int unsigned FIS_LEN_OK = 128;
endpackage

// File: rtl/cslot_issue_reg.sv
module cslot_issue_reg #(
  parameter int NSLOT = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NSLOT-1:0] set_mask,
  input  logic [NSLOT-1:0] clr_mask,
  output logic [NSLOT-1:0] bits_q
);
  for (genvar i = 0; i < NSLOT; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)              bits_q[i] <= 1'b0;
      else if (set_mask[i]) bits_q[i] <= 1'b1;
      else if (clr_mask[i]) bits_q[i] <= 1'b0;
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
      set_mask[i] |=> bits_q[i]); // R10
    AST_CLEAR_SOURCE: assert property (@(posedge clk) disable iff (rst)
      $fell(bits_q[i]) |-> $past(clr_mask[i])); // R10
  end
endmodule

// File: rtl/cslot_pick.sv
module cslot_pick #(
  parameter int NSLOT = 32,
  localparam int SW = $clog2(NSLOT)
) (
  input  logic [NSLOT-1:0] req,
  output logic             found,
  output logic [SW-1:0]    idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = NSLOT - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = SW'(i);
      end
    end
  end
endmodule

// File: rtl/cmd_slot_dispatcher.sv
module cmd_slot_dispatcher
  import cslot_pkg::*;
#(
  parameter int NSLOT = 32,
  parameter int LEN_W = 8,
  parameter int OPC_W = 8,
  localparam int SW = $clog2(NSLOT),
  localparam int BW = SW + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             issue_wr,
  input  logic [NSLOT-1:0] issue_set,
  input  logic             start_wr,
  input  logic             start_val,
  input  logic             eng_busy,
  input  logic             eng_drq,
  input  logic             eng_err,
  input  logic             eng_done,
  output logic [SW-1:0]    hdr_slot,
  input  logic [LEN_W-1:0] hdr_fis_len,
  input  logic [OPC_W-1:0] hdr_cmd_byte,
  input  logic             hdr_ncq,
  output logic             disp_valid,
  output logic [SW-1:0]    disp_slot,
  output logic [OPC_W-1:0] disp_opcode,
  output logic             disp_ncq,
  output logic             irq_hbf,
  output logic             irq_tfe,
  output logic             irq_d2h,
  output logic [NSLOT-1:0] ci_bits,
  output logic             port_run,
  output logic [BW-1:0]    active_slot
);
  localparam logic [BW-1:0] SLOT_NONE = '1;

  phase_e           ph_q;
  logic [SW-1:0]    look_q;
  logic [BW-1:0]    act_q;
  logic             run_q;
  logic [NSLOT-1:0] ci_q;
  logic [NSLOT-1:0] set_mask, clr_mask;
  logic             pk_found;
  logic [SW-1:0]    pk_idx;
  logic             eng_idle, scan_go, len_ok, act_done;

  assign eng_idle = !eng_busy && !eng_drq;
  assign len_ok   = (hdr_fis_len == LEN_W'(FIS_LEN_OK));
  assign act_done = eng_done && (act_q != SLOT_NONE);
  assign scan_go  = (ph_q == PH_SCAN) && run_q && pk_found && eng_idle &&
                    (act_q == SLOT_NONE);

  cslot_pick #(.NSLOT(NSLOT)) u_pick (
    .req   (ci_q),
    .found (pk_found),
    .idx   (pk_idx)
  );

  always_comb begin
    set_mask = issue_wr ? issue_set : '0;
    clr_mask = '0;
    if (ph_q == PH_ACCEPT && eng_idle) clr_mask[look_q] = 1'b1;
    if (act_done && eng_idle)          clr_mask[act_q[SW-1:0]] = 1'b1;
  end

  cslot_issue_reg #(.NSLOT(NSLOT)) u_issue (
    .clk      (clk),
    .rst      (rst),
    .set_mask (set_mask),
    .clr_mask (clr_mask),
    .bits_q   (ci_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q        <= PH_SCAN;
      look_q      <= '0;
      act_q       <= SLOT_NONE;
      run_q       <= 1'b0;
      disp_valid  <= 1'b0;
      disp_slot   <= '0;
      disp_opcode <= '0;
      disp_ncq    <= 1'b0;
      irq_hbf     <= 1'b0;
      irq_tfe     <= 1'b0;
      irq_d2h     <= 1'b0;
    end else begin
      disp_valid <= 1'b0;
      irq_hbf    <= 1'b0;
      irq_tfe    <= 1'b0;
      irq_d2h    <= 1'b0;
      case (ph_q)
        PH_SCAN: begin
          if (scan_go) begin
            look_q <= pk_idx;
            ph_q   <= PH_LOOK;
          end
        end
        PH_LOOK: begin
          if (!len_ok) begin
            irq_hbf <= 1'b1;
            ph_q    <= PH_SCAN;
          end else begin
            disp_valid  <= 1'b1;
            disp_slot   <= look_q;
            disp_opcode <= hdr_cmd_byte;
            disp_ncq    <= hdr_ncq;
            if (hdr_ncq) begin
              ph_q <= PH_ACCEPT;
            end else begin
              act_q <= {1'b0, look_q};
              ph_q  <= PH_SCAN;
            end
          end
        end
        default: begin
          if (eng_err) irq_tfe <= 1'b1;
          ph_q <= PH_SCAN;
        end
      endcase
      if (act_done) begin
        act_q   <= SLOT_NONE;
        irq_d2h <= 1'b1;
        if (eng_err) irq_tfe <= 1'b1;
      end
      if (ph_q == PH_LOOK && !len_ok) run_q <= 1'b0;
      else if (start_wr)              run_q <= start_val;
    end
  end

  assign hdr_slot    = look_q;
  assign ci_bits     = ci_q;
  assign port_run    = run_q;
  assign active_slot = act_q;

  AST_DISP_PULSE: assert property (@(posedge clk) disable iff (rst)
    disp_valid |=> !disp_valid); // R5
  AST_IDLE_GATE: assert property (@(posedge clk) disable iff (rst)
    (ph_q == PH_LOOK) |-> $past(run_q && !eng_busy && !eng_drq)); // R3
  AST_HBF_NOEXEC: assert property (@(posedge clk) disable iff (rst)
    irq_hbf |-> (!disp_valid && !run_q)); // R4
  AST_NCQ_NO_D2H: assert property (@(posedge clk) disable iff (rst)
    (disp_valid && disp_ncq) |=> !irq_d2h); // R6
  AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (act_q != SLOT_NONE && !eng_done) |=> $stable(act_q)); // R7
  AST_ACT_RELEASE: assert property (@(posedge clk) disable iff (rst)
    act_done |=> (act_q == SLOT_NONE)); // R8
endmodule

// File: tb/test_cmd_slot_dispatcher.sv
module test_cmd_slot_dispatcher;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic issue_wr = 1'b0;
  logic [31:0] issue_set = '0;
  logic start_wr = 1'b0, start_val = 1'b0;
  logic eng_busy = 1'b0, eng_drq = 1'b0, eng_err = 1'b0, eng_done = 1'b0;
  logic [4:0] hdr_slot;
  logic [7:0] hdr_fis_len, hdr_cmd_byte;
  logic hdr_ncq;
  logic disp_valid, disp_ncq, irq_hbf, irq_tfe, irq_d2h, port_run;
  logic [4:0] disp_slot;
  logic [7:0] disp_opcode;
  logic [31:0] ci_bits;
  logic [5:0] active_slot;

  logic [7:0] tb_len [32];
  logic [7:0] tb_opc [32];
  logic       tb_ncq [32];

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  assign hdr_fis_len  = tb_len[hdr_slot];
  assign hdr_cmd_byte = tb_opc[hdr_slot];
  assign hdr_ncq      = tb_ncq[hdr_slot];

  always #(CLK_PERIOD / 2) clk = ~clk;

  cmd_slot_dispatcher i_cmd_slot_dispatcher (
    .clk(clk), .rst(rst), .issue_wr(issue_wr), .issue_set(issue_set),
    .start_wr(start_wr), .start_val(start_val), .eng_busy(eng_busy),
    .eng_drq(eng_drq), .eng_err(eng_err), .eng_done(eng_done),
    .hdr_slot(hdr_slot), .hdr_fis_len(hdr_fis_len), .hdr_cmd_byte(hdr_cmd_byte),
    .hdr_ncq(hdr_ncq), .disp_valid(disp_valid), .disp_slot(disp_slot),
    .disp_opcode(disp_opcode), .disp_ncq(disp_ncq), .irq_hbf(irq_hbf),
    .irq_tfe(irq_tfe), .irq_d2h(irq_d2h), .ci_bits(ci_bits),
    .port_run(port_run), .active_slot(active_slot)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; issue_wr = 1'b0; issue_set = '0; start_wr = 1'b0; start_val = 1'b0;
    eng_busy = 1'b0; eng_drq = 1'b0; eng_err = 1'b0; eng_done = 1'b0;
    for (int i = 0; i < 32; i++) begin
      tb_len[i] = 8'd128;
      tb_opc[i] = 8'h40 + 8'(i);
      tb_ncq[i] = 1'b1;
    end
    tick(); tick();
    rst = 1'b0;
  endtask

  task automatic wr_issue(logic [31:0] m);
    issue_wr = 1'b1; issue_set = m;
    tick();
    issue_wr = 1'b0; issue_set = '0;
  endtask

  task automatic wr_start(logic v);
    start_wr = 1'b1; start_val = v;
    tick();
    start_wr = 1'b0;
  endtask

  task automatic expect_disp(string req, int slot);
    chk(req, "disp_valid", 64'(disp_valid), 64'd1);
    chk(req, "disp_slot", 64'(disp_slot), 64'(slot));
  endtask

  task automatic quiet(string req, int cycles);
    int seen = 0;
    for (int k = 0; k < cycles; k++) begin
      tick();
      if (disp_valid) seen++;
    end
    chk(req, "dispatch count while held", 64'(seen), 64'd0);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1", "ci_bits", 64'(ci_bits), 64'd0);
    chk("R1", "port_run", 64'(port_run), 64'd0);
    chk("R1", "active_slot", 64'(active_slot), 64'h3F);
    chk("R1", "disp_valid", 64'(disp_valid), 64'd0);
    quiet("R1", 4);
  endtask

  task automatic t_start_gate();
    do_reset();
    wr_issue(32'h10);
    quiet("R2", 6);
    chk("R2", "ci bit 4 while stopped", 64'(ci_bits[4]), 64'd1);
    wr_start(1'b1);
    tick(); tick();
    expect_disp("R2", 4);
  endtask

  task automatic t_order();
    do_reset();
    wr_start(1'b1);
    wr_issue((32'h1 << 2) | (32'h1 << 7) | (32'h1 << 30));
    tick(); tick();
    expect_disp("R2", 2);
    chk("R5", "disp_opcode", 64'(disp_opcode), 64'h42);
    chk("R5", "disp_ncq", 64'(disp_ncq), 64'd1);
    tick();
    chk("R5", "pulse ends", 64'(disp_valid), 64'd0);
    chk("R6", "ncq bit 2 cleared", 64'(ci_bits[2]), 64'd0);
    chk("R6", "no d2h for ncq", 64'(irq_d2h), 64'd0);
    tick(); tick();
    expect_disp("R2", 7);
    tick(); tick(); tick();
    expect_disp("R2", 30);
    tick();
    chk("R6", "all cleared", 64'(ci_bits), 64'd0);
  endtask

  task automatic t_busy();
    do_reset();
    wr_start(1'b1);
    eng_busy = 1'b1;
    wr_issue(32'h2);
    quiet("R3", 5);
    eng_busy = 1'b0; eng_drq = 1'b1;
    quiet("R3", 4);
    chk("R3", "ci bit 1 held", 64'(ci_bits[1]), 64'd1);
    eng_drq = 1'b0;
    tick(); tick();
    expect_disp("R3", 1);
  endtask

  task automatic t_hbf();
    do_reset();
    tb_len[5] = 8'd64;
    wr_start(1'b1);
    wr_issue(32'h20);
    tick(); tick();
    chk("R4", "irq_hbf", 64'(irq_hbf), 64'd1);
    chk("R4", "no dispatch", 64'(disp_valid), 64'd0);
    chk("R4", "run cleared", 64'(port_run), 64'd0);
    chk("R4", "ci bit 5 kept", 64'(ci_bits[5]), 64'd1);
    tick();
    chk("R4", "irq_hbf pulse ends", 64'(irq_hbf), 64'd0);
    quiet("R4", 4);
  endtask

  task automatic t_nonq();
    do_reset();
    tb_ncq[3] = 1'b0; tb_ncq[12] = 1'b0; tb_opc[3] = 8'hC8;
    wr_start(1'b1);
    wr_issue((32'h1 << 3) | (32'h1 << 12));
    tick(); tick();
    expect_disp("R7", 3);
    chk("R5", "opcode from byte 2", 64'(disp_opcode), 64'hC8);
    chk("R7", "disp_ncq", 64'(disp_ncq), 64'd0);
    chk("R7", "active_slot", 64'(active_slot), 64'd3);
    eng_busy = 1'b1;
    quiet("R7", 4);
    chk("R7", "ci bits held", 64'(ci_bits), 64'h1008);
    eng_busy = 1'b0;
    quiet("R7", 3);
    eng_done = 1'b1;
    tick();
    eng_done = 1'b0;
    chk("R8", "bit 3 cleared", 64'(ci_bits[3]), 64'd0);
    chk("R8", "active none", 64'(active_slot), 64'h3F);
    chk("R8", "irq_d2h", 64'(irq_d2h), 64'd1);
    chk("R8", "irq_tfe quiet", 64'(irq_tfe), 64'd0);
    tick(); tick();
    expect_disp("R9", 12);
  endtask

  task automatic t_done_gated();
    do_reset();
    tb_ncq[8] = 1'b0;
    wr_start(1'b1);
    wr_issue(32'h100);
    tick(); tick();
    expect_disp("R8", 8);
    eng_drq = 1'b1; eng_err = 1'b1; eng_done = 1'b1;
    tick();
    eng_done = 1'b0; eng_err = 1'b0; eng_drq = 1'b0;
    chk("R8", "gated bit 8 kept", 64'(ci_bits[8]), 64'd1);
    chk("R8", "active none", 64'(active_slot), 64'h3F);
    chk("R8", "irq_tfe", 64'(irq_tfe), 64'd1);
    chk("R8", "irq_d2h", 64'(irq_d2h), 64'd1);
    tick(); tick();
    expect_disp("R9", 8);
  endtask

  task automatic t_ncq_gate();
    do_reset();
    wr_start(1'b1);
    wr_issue(32'h40);
    tick(); tick();
    expect_disp("R6", 6);
    eng_drq = 1'b1; eng_err = 1'b1;
    tick();
    chk("R6", "gated bit 6 kept", 64'(ci_bits[6]), 64'd1);
    chk("R6", "irq_tfe", 64'(irq_tfe), 64'd1);
    chk("R6", "irq_d2h", 64'(irq_d2h), 64'd0);
    eng_drq = 1'b0; eng_err = 1'b0;
    tick(); tick();
    expect_disp("R6", 6);
    tick();
    chk("R6", "bit 6 cleared", 64'(ci_bits[6]), 64'd0);
  endtask

  task automatic t_set_wins();
    do_reset();
    wr_start(1'b1);
    wr_issue(32'h800);
    tick(); tick();
    expect_disp("R10", 11);
    issue_wr = 1'b1; issue_set = 32'h800;
    tick();
    issue_wr = 1'b0; issue_set = '0;
    chk("R10", "set beats clear", 64'(ci_bits[11]), 64'd1);
    tick(); tick();
    expect_disp("R10", 11);
    tick();
    chk("R10", "later clear", 64'(ci_bits[11]), 64'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_start_gate();
    t_order();
    t_busy();
    t_hbf();
    t_nonq();
    t_done_gated();
    t_ncq_gate();
    t_set_wins();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule